// File: doc/BRIEF.md
# Hit-Register Bus Register Interface

This block is the register front end of a sixteen-channel hit register. A bus master issues single-cycle requests carrying a write flag, a byte offset and sixteen bits of write data. The block answers one cycle later with an acknowledge and, for reads, the addressed word. Configuration words are held here and driven out to the channel logic:
- input set and input mask,
- output set and output mask,
- interrupt mask, interrupt level and interrupt vector,
- the mode, gate mask and OR mask control bits,
- the test-channel masks.

Status words enter on input ports and are returned on reads: the raw input levels, the first-level (single-hit) flags, the second-level (multi-hit) flags and the raw pushbutton.

Some accesses act as commands. Reading either of two alias offsets returns a hit word and then pulses a one-cycle clear strobe toward the channel flags. Any write to the clear offset pulses a global clear, whatever the data. Any write to the software-reset offset returns every register to its default. A scratch word lets software test the data path.

Top module: `hreg_regif`

## Requirements
- R1: Out of reset: the input set, input mask, output set, output mask and interrupt mask words are 0x0000; the interrupt level is 0; the interrupt vector is the VECTOR_RST parameter (default 0xDD); mode is 0, gate mask is 1 and OR mask is 0; the test masks are 0; the scratch word is 0x5555; all strobes and ack_o are low.
- R2: A request in one cycle gives ack_o high for exactly the next cycle. For a read, rdata_o holds the addressed word in that same cycle.
- R3: The words at byte offsets 0x00 (input set), 0x02 (input mask), 0x0A (output set), 0x0C (output mask) and 0x0E (interrupt mask) are read/write. A write drives the matching output port in the ack cycle, and a read returns the stored value.
- R4: Reads of 0x04, 0x06 and 0x08 return in_level_i, single_hit_i and multi_hit_i as sampled at the request edge. These reads pulse no clear strobe.
- R5: A read of 0x16 returns single_hit_i and raises single_clr_o for exactly the ack cycle. A read of 0x18 does the same with multi_hit_i and multi_clr_o. Neither read raises the other strobe.
- R6: Any write to 0x10 raises clear_all_o for exactly the ack cycle and zeroes the input set word. A read of 0x10 returns 0.
- R7: Test control at 0x1A:
  - bit 0 is the test output mask, bit 1 the test OR mask and bit 2 the test interrupt mask, all read/write;
  - writing 1 to bit 3 pulses test_clr_o for the ack cycle, and bit 3 reads as 0;
  - bit 4 reads test_button_i;
  - the other bits read 0.
- R8: The interrupt level at 0x20 keeps write bits [2:0]. The interrupt vector at 0x22 keeps write bits [7:0]. The upper bits of both read as 0.
- R9: 0x24 reads the SERIAL_NO parameter and 0x26 reads the FW_REV parameter. Writes to 0x24, 0x26 and 0x04 change nothing.
- R10: Control at 0x28: bit 0 is mode, bit 1 is gate mask and bit 2 is OR mask. The upper bits read 0.
- R11: The scratch word at 0x2A is a full sixteen-bit read/write word.
- R12: Any write to 0x2E returns every register to its R1 value, visible in the ack cycle.
- R13: Reads of reserved offsets (0x12, 0x14, 0x1C, 0x1E, 0x2C, 0x30 and above) and of any odd offset return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Access done, one cycle after the request |
| rdata_o | output | 16 | Read data, valid with ack_o |
| in_level_i | input | 16 | Raw input levels |
| single_hit_i | input | 16 | First-level hit flags |
| multi_hit_i | input | 16 | Second-level hit flags |
| test_button_i | input | 1 | Raw test pushbutton |
| in_set_o | output | 16 | Input set word |
| in_mask_o | output | 16 | Input mask word |
| out_set_o | output | 16 | Output set word |
| out_mask_o | output | 16 | Output mask word |
| irq_mask_o | output | 16 | Interrupt mask word |
| irq_level_o | output | 3 | Interrupt level |
| irq_vector_o | output | 8 | Interrupt vector |
| mode_o | output | 1 | Mode select |
| gate_mask_o | output | 1 | Gate mask |
| or_mask_o | output | 1 | OR output mask |
| test_out_mask_o | output | 1 | Test output mask |
| test_or_mask_o | output | 1 | Test channel OR mask |
| test_irq_mask_o | output | 1 | Test channel interrupt mask |
| clear_all_o | output | 1 | Global clear strobe |
| single_clr_o | output | 1 | First-level flag clear strobe |
| multi_clr_o | output | 1 | Second-level flag clear strobe |
| test_clr_o | output | 1 | Test flag clear strobe |

## Verification
The hardest case to bring about is a read-to-clear alias whose strobe must rise in exactly the ack cycle and nowhere else. The matching case on the other side is a command write whose data must not matter. The bench holds a distinct, non-zero pattern on each status input before every read, then samples the data, both clear strobes and the global clear together in the ack cycle. It also samples once more a cycle later, to see that the strobe has dropped. Writes of all-ones to the reserved offsets and to the read-only words are followed by reads and output checks. These show that nothing moved.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int WIDX_W  = ADDR_W - 1;
    localparam int LEVEL_W = 3;
    localparam int VEC_W   = 8;

    // word indices (byte offset / 2)
    localparam logic [WIDX_W-1:0] W_IN_SET   = 5'd0;
    localparam logic [WIDX_W-1:0] W_IN_MASK  = 5'd1;
    localparam logic [WIDX_W-1:0] W_IN_LEVEL = 5'd2;
    localparam logic [WIDX_W-1:0] W_SHIT     = 5'd3;
    localparam logic [WIDX_W-1:0] W_MHIT     = 5'd4;
    localparam logic [WIDX_W-1:0] W_OUT_SET  = 5'd5;
    localparam logic [WIDX_W-1:0] W_OUT_MASK = 5'd6;
    localparam logic [WIDX_W-1:0] W_IRQ_MASK = 5'd7;
    localparam logic [WIDX_W-1:0] W_CLEAR    = 5'd8;
    localparam logic [WIDX_W-1:0] W_SHIT_RC  = 5'd11;
    localparam logic [WIDX_W-1:0] W_MHIT_RC  = 5'd12;
    localparam logic [WIDX_W-1:0] W_TEST     = 5'd13;
    localparam logic [WIDX_W-1:0] W_LEVEL    = 5'd16;
    localparam logic [WIDX_W-1:0] W_VECTOR   = 5'd17;
    localparam logic [WIDX_W-1:0] W_SERIAL   = 5'd18;
    localparam logic [WIDX_W-1:0] W_FWREV    = 5'd19;
    localparam logic [WIDX_W-1:0] W_CTRL     = 5'd20;
    localparam logic [WIDX_W-1:0] W_SCRATCH  = 5'd21;
    localparam logic [WIDX_W-1:0] W_SWRST    = 5'd23;

    // test control bit positions
    localparam int TB_OUT_MASK = 0;
    localparam int TB_OR_MASK  = 1;
    localparam int TB_IRQ_MASK = 2;
    localparam int TB_CLEAR    = 3;
    localparam int TB_BUTTON   = 4;

    // control bit positions
    localparam int CB_MODE      = 0;
    localparam int CB_GATE_MASK = 1;
    localparam int CB_OR_MASK   = 2;

    localparam logic [DATA_W-1:0] SCRATCH_RST = 16'h5555;

    typedef struct packed {
        logic [DATA_W-1:0]  in_set;
        logic [DATA_W-1:0]  in_mask;
        logic [DATA_W-1:0]  out_set;
        logic [DATA_W-1:0]  out_mask;
        logic [DATA_W-1:0]  irq_mask;
        logic [DATA_W-1:0]  scratch;
        logic [LEVEL_W-1:0] irq_level;
        logic [VEC_W-1:0]   irq_vector;
        logic               mode;
        logic               gate_mask;
        logic               or_mask;
        logic               t_out_mask;
        logic               t_or_mask;
        logic               t_irq_mask;
    } cfg_t;

    // decoded access enables for one request
    typedef struct packed {
        logic wr_in_set;
        logic wr_in_mask;
        logic wr_out_set;
        logic wr_out_mask;
        logic wr_irq_mask;
        logic wr_clear;
        logic wr_test;
        logic wr_level;
        logic wr_vector;
        logic wr_ctrl;
        logic wr_scratch;
        logic wr_swrst;
        logic rd_shit_rc;
        logic rd_mhit_rc;
        logic rd_any;
    } acc_t;

endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
    import hreg_pkg::*;
(
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_t              acc_o
);

    logic [WIDX_W-1:0] idx;
    logic              wr;
    logic              rd;
    logic              even;

    assign idx  = addr_i[ADDR_W-1:1];
    assign even = ~addr_i[0];
    assign wr   = req_i & we_i & even;
    assign rd   = req_i & ~we_i;

    always_comb begin
        acc_o        = '0;
        acc_o.rd_any = rd;
        if (wr) begin
            unique case (idx)
                W_IN_SET:   acc_o.wr_in_set   = 1'b1;
                W_IN_MASK:  acc_o.wr_in_mask  = 1'b1;
                W_OUT_SET:  acc_o.wr_out_set  = 1'b1;
                W_OUT_MASK: acc_o.wr_out_mask = 1'b1;
                W_IRQ_MASK: acc_o.wr_irq_mask = 1'b1;
                W_CLEAR:    acc_o.wr_clear    = 1'b1;
                W_TEST:     acc_o.wr_test     = 1'b1;
                W_LEVEL:    acc_o.wr_level    = 1'b1;
                W_VECTOR:   acc_o.wr_vector   = 1'b1;
                W_CTRL:     acc_o.wr_ctrl     = 1'b1;
                W_SCRATCH:  acc_o.wr_scratch  = 1'b1;
                W_SWRST:    acc_o.wr_swrst    = 1'b1;
                default:    ;
            endcase
        end
        if (rd && even) begin
            acc_o.rd_shit_rc = (idx == W_SHIT_RC);
            acc_o.rd_mhit_rc = (idx == W_MHIT_RC);
        end
    end

endmodule

// File: rtl/hreg_readmux.sv
module hreg_readmux
    import hreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] SERIAL_NO = 16'h0001,
    parameter logic [DATA_W-1:0] FW_REV    = 16'h0100
)(
    input  logic [ADDR_W-1:0] addr_i,
    input  cfg_t              cfg_i,
    input  logic [DATA_W-1:0] in_level_i,
    input  logic [DATA_W-1:0] single_hit_i,
    input  logic [DATA_W-1:0] multi_hit_i,
    input  logic              test_button_i,
    output logic [DATA_W-1:0] rd_word_o
);

    logic [WIDX_W-1:0] idx;
    logic [DATA_W-1:0] test_word;
    logic [DATA_W-1:0] ctrl_word;

    assign idx = addr_i[ADDR_W-1:1];

    always_comb begin
        test_word               = '0;
        test_word[TB_OUT_MASK]  = cfg_i.t_out_mask;
        test_word[TB_OR_MASK]   = cfg_i.t_or_mask;
        test_word[TB_IRQ_MASK]  = cfg_i.t_irq_mask;
        test_word[TB_BUTTON]    = test_button_i;
        ctrl_word               = '0;
        ctrl_word[CB_MODE]      = cfg_i.mode;
        ctrl_word[CB_GATE_MASK] = cfg_i.gate_mask;
        ctrl_word[CB_OR_MASK]   = cfg_i.or_mask;
    end

    always_comb begin
        rd_word_o = '0;
        if (!addr_i[0]) begin
            unique case (idx)
                W_IN_SET:   rd_word_o = cfg_i.in_set;
                W_IN_MASK:  rd_word_o = cfg_i.in_mask;
                W_IN_LEVEL: rd_word_o = in_level_i;
                W_SHIT,
                W_SHIT_RC:  rd_word_o = single_hit_i;
                W_MHIT,
                W_MHIT_RC:  rd_word_o = multi_hit_i;
                W_OUT_SET:  rd_word_o = cfg_i.out_set;
                W_OUT_MASK: rd_word_o = cfg_i.out_mask;
                W_IRQ_MASK: rd_word_o = cfg_i.irq_mask;
                W_TEST:     rd_word_o = test_word;
                W_LEVEL:    rd_word_o = {{(DATA_W-LEVEL_W){1'b0}}, cfg_i.irq_level};
                W_VECTOR:   rd_word_o = {{(DATA_W-VEC_W){1'b0}}, cfg_i.irq_vector};
                W_SERIAL:   rd_word_o = SERIAL_NO;
                W_FWREV:    rd_word_o = FW_REV;
                W_CTRL:     rd_word_o = ctrl_word;
                W_SCRATCH:  rd_word_o = cfg_i.scratch;
                default:    rd_word_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/hreg_state.sv
module hreg_state
    import hreg_pkg::*;
#(
    parameter logic [VEC_W-1:0] VECTOR_RST = 8'hDD
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  acc_t              acc_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output cfg_t              cfg_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clear_all_o,
    output logic              single_clr_o,
    output logic              multi_clr_o,
    output logic              test_clr_o
);

    typedef struct packed {
        cfg_t              cfg;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic              clr_all;
        logic              sclr;
        logic              mclr;
        logic              tclr;
    } st_t;

    localparam cfg_t CFG_RST = '{
        in_set:     '0,
        in_mask:    '0,
        out_set:    '0,
        out_mask:   '0,
        irq_mask:   '0,
        scratch:    SCRATCH_RST,
        irq_level:  '0,
        irq_vector: VECTOR_RST,
        mode:       1'b0,
        gate_mask:  1'b1,
        or_mask:    1'b0,
        t_out_mask: 1'b0,
        t_or_mask:  1'b0,
        t_irq_mask: 1'b0
    };

    localparam st_t ST_RST = '{
        cfg:     CFG_RST,
        ack:     1'b0,
        rdata:   '0,
        clr_all: 1'b0,
        sclr:    1'b0,
        mclr:    1'b0,
        tclr:    1'b0
    };

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ack     = req_i;
        st_d.rdata   = acc_i.rd_any ? rd_word_i : '0;
        st_d.clr_all = 1'b0;
        st_d.sclr    = acc_i.rd_shit_rc;
        st_d.mclr    = acc_i.rd_mhit_rc;
        st_d.tclr    = 1'b0;

        if (acc_i.wr_in_set)   st_d.cfg.in_set   = wdata_i;
        if (acc_i.wr_in_mask)  st_d.cfg.in_mask  = wdata_i;
        if (acc_i.wr_out_set)  st_d.cfg.out_set  = wdata_i;
        if (acc_i.wr_out_mask) st_d.cfg.out_mask = wdata_i;
        if (acc_i.wr_irq_mask) st_d.cfg.irq_mask = wdata_i;
        if (acc_i.wr_scratch)  st_d.cfg.scratch  = wdata_i;
        if (acc_i.wr_level)    st_d.cfg.irq_level  = wdata_i[LEVEL_W-1:0];
        if (acc_i.wr_vector)   st_d.cfg.irq_vector = wdata_i[VEC_W-1:0];
        if (acc_i.wr_ctrl) begin
            st_d.cfg.mode      = wdata_i[CB_MODE];
            st_d.cfg.gate_mask = wdata_i[CB_GATE_MASK];
            st_d.cfg.or_mask   = wdata_i[CB_OR_MASK];
        end
        if (acc_i.wr_test) begin
            st_d.cfg.t_out_mask = wdata_i[TB_OUT_MASK];
            st_d.cfg.t_or_mask  = wdata_i[TB_OR_MASK];
            st_d.cfg.t_irq_mask = wdata_i[TB_IRQ_MASK];
            st_d.tclr           = wdata_i[TB_CLEAR];
        end
        if (acc_i.wr_clear) begin
            st_d.clr_all    = 1'b1;
            st_d.cfg.in_set = '0;
        end
        if (acc_i.wr_swrst) begin
            st_d.cfg = CFG_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign cfg_o        = st_q.cfg;
    assign ack_o        = st_q.ack;
    assign rdata_o      = st_q.rdata;
    assign clear_all_o  = st_q.clr_all;
    assign single_clr_o = st_q.sclr;
    assign multi_clr_o  = st_q.mclr;
    assign test_clr_o   = st_q.tclr;

endmodule

// File: rtl/hreg_regif.sv
module hreg_regif
    import hreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] SERIAL_NO  = 16'h0001,
    parameter logic [DATA_W-1:0] FW_REV     = 16'h0100,
    parameter logic [VEC_W-1:0]  VECTOR_RST = 8'hDD
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               ack_o,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [DATA_W-1:0]  in_level_i,
    input  logic [DATA_W-1:0]  single_hit_i,
    input  logic [DATA_W-1:0]  multi_hit_i,
    input  logic               test_button_i,
    output logic [DATA_W-1:0]  in_set_o,
    output logic [DATA_W-1:0]  in_mask_o,
    output logic [DATA_W-1:0]  out_set_o,
    output logic [DATA_W-1:0]  out_mask_o,
    output logic [DATA_W-1:0]  irq_mask_o,
    output logic [LEVEL_W-1:0] irq_level_o,
    output logic [VEC_W-1:0]   irq_vector_o,
    output logic               mode_o,
    output logic               gate_mask_o,
    output logic               or_mask_o,
    output logic               test_out_mask_o,
    output logic               test_or_mask_o,
    output logic               test_irq_mask_o,
    output logic               clear_all_o,
    output logic               single_clr_o,
    output logic               multi_clr_o,
    output logic               test_clr_o
);

    acc_t              acc;
    cfg_t              cfg;
    logic [DATA_W-1:0] rd_word;

    hreg_decode u_decode (
        .req_i  (req_i),
        .we_i   (we_i),
        .addr_i (addr_i),
        .acc_o  (acc)
    );

    hreg_readmux #(
        .SERIAL_NO (SERIAL_NO),
        .FW_REV    (FW_REV)
    ) u_readmux (
        .addr_i        (addr_i),
        .cfg_i         (cfg),
        .in_level_i    (in_level_i),
        .single_hit_i  (single_hit_i),
        .multi_hit_i   (multi_hit_i),
        .test_button_i (test_button_i),
        .rd_word_o     (rd_word)
    );

    hreg_state #(
        .VECTOR_RST (VECTOR_RST)
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .acc_i        (acc),
        .wdata_i      (wdata_i),
        .rd_word_i    (rd_word),
        .cfg_o        (cfg),
        .ack_o        (ack_o),
        .rdata_o      (rdata_o),
        .clear_all_o  (clear_all_o),
        .single_clr_o (single_clr_o),
        .multi_clr_o  (multi_clr_o),
        .test_clr_o   (test_clr_o)
    );

    assign in_set_o        = cfg.in_set;
    assign in_mask_o       = cfg.in_mask;
    assign out_set_o       = cfg.out_set;
    assign out_mask_o      = cfg.out_mask;
    assign irq_mask_o      = cfg.irq_mask;
    assign irq_level_o     = cfg.irq_level;
    assign irq_vector_o    = cfg.irq_vector;
    assign mode_o          = cfg.mode;
    assign gate_mask_o     = cfg.gate_mask;
    assign or_mask_o       = cfg.or_mask;
    assign test_out_mask_o = cfg.t_out_mask;
    assign test_or_mask_o  = cfg.t_or_mask;
    assign test_irq_mask_o = cfg.t_irq_mask;

endmodule

// File: rtl/hreg_regif_chk.sv
module hreg_regif_chk
    import hreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ack_o,
    input logic [DATA_W-1:0] in_set_o,
    input logic [DATA_W-1:0] in_mask_o,
    input logic [DATA_W-1:0] out_set_o,
    input logic              mode_o,
    input logic              gate_mask_o,
    input logic              clear_all_o,
    input logic              single_clr_o,
    input logic              multi_clr_o
);

    logic rd_srcl, rd_mrcl, wr_clr, wr_rst;
    assign rd_srcl = req_i && !we_i && addr_i == {W_SHIT_RC, 1'b0};
    assign rd_mrcl = req_i && !we_i && addr_i == {W_MHIT_RC, 1'b0};
    assign wr_clr  = req_i && we_i  && addr_i == {W_CLEAR, 1'b0};
    assign wr_rst  = req_i && we_i  && addr_i == {W_SWRST, 1'b0};

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ack_o);
    assert_no_ack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !ack_o);
    assert_single_clr_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_srcl |=> (single_clr_o && !multi_clr_o));
    assert_multi_clr_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mrcl |=> (multi_clr_o && !single_clr_o));
    assert_single_clr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        single_clr_o |-> $past(rd_srcl));
    assert_clear_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (clear_all_o && in_set_o == '0));
    assert_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all_o |-> $past(wr_clr));
    assert_swreset_defaults_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> (in_mask_o == '0 && out_set_o == '0 && gate_mask_o && !mode_o));

endmodule

bind hreg_regif hreg_regif_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .ack_o        (ack_o),
    .in_set_o     (in_set_o),
    .in_mask_o    (in_mask_o),
    .out_set_o    (out_set_o),
    .mode_o       (mode_o),
    .gate_mask_o  (gate_mask_o),
    .clear_all_o  (clear_all_o),
    .single_clr_o (single_clr_o),
    .multi_clr_o  (multi_clr_o)
);

// File: tb/hreg_regif_tb_top.sv
module hreg_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        ack_o;
    logic [15:0] rdata_o;
    logic [15:0] in_level_i = '0, single_hit_i = '0, multi_hit_i = '0;
    logic        test_button_i = 1'b0;
    logic [15:0] in_set_o, in_mask_o, out_set_o, out_mask_o, irq_mask_o;
    logic [2:0]  irq_level_o;
    logic [7:0]  irq_vector_o;
    logic        mode_o, gate_mask_o, or_mask_o;
    logic        test_out_mask_o, test_or_mask_o, test_irq_mask_o;
    logic        clear_all_o, single_clr_o, multi_clr_o, test_clr_o;

    localparam logic [15:0] SER = 16'h1A2B;
    localparam logic [15:0] FW  = 16'h0302;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // values sampled in the ack cycle
    logic [15:0] s_rdata;
    logic        s_ack, s_sclr, s_mclr, s_call, s_tclr;

    always #10 clk = ~clk;

    hreg_regif #(.SERIAL_NO(SER), .FW_REV(FW), .VECTOR_RST(8'hDD)) dut_i (.*);

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        s_rdata = rdata_o; s_ack = ack_o;
        s_sclr = single_clr_o; s_mclr = multi_clr_o;
        s_call = clear_all_o; s_tclr = test_clr_o;
        chk("R2", "ack", {15'b0, s_ack}, 16'h1);
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string req);
        bus(1'b0, a, 16'h0);
        chk(req, $sformatf("read @%h", a), s_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R1", "in_set", in_set_o, 0);
        chk("R1", "in_mask", in_mask_o, 0);
        chk("R1", "out_set", out_set_o, 0);
        chk("R1", "out_mask", out_mask_o, 0);
        chk("R1", "irq_mask", irq_mask_o, 0);
        chk("R1", "level", {13'b0, irq_level_o}, 0);
        chk("R1", "vector", {8'b0, irq_vector_o}, 16'hDD);
        chk("R1", "ctrl bits", {13'b0, or_mask_o, gate_mask_o, mode_o}, 16'h2);
        chk("R1", "test masks", {13'b0, test_irq_mask_o, test_or_mask_o, test_out_mask_o}, 0);
        chk("R1", "strobes", {11'b0, ack_o, clear_all_o, single_clr_o, multi_clr_o, test_clr_o}, 0);
        rd(6'h2A, 16'h5555, "R1");
        rd(6'h28, 16'h0002, "R1");
    endtask

    task automatic t_rw();
        logic [15:0] p [2] = '{16'hA5F0, 16'h0F3C};
        foreach (p[k]) begin
            bus(1'b1, 6'h00, p[k]);       chk("R3", "in_set_o", in_set_o, p[k]);
            bus(1'b1, 6'h02, p[k] ^ 16'h1); chk("R3", "in_mask_o", in_mask_o, p[k] ^ 16'h1);
            bus(1'b1, 6'h0A, ~p[k]);      chk("R3", "out_set_o", out_set_o, ~p[k]);
            bus(1'b1, 6'h0C, p[k] + 16'h3); chk("R3", "out_mask_o", out_mask_o, p[k] + 16'h3);
            bus(1'b1, 6'h0E, {p[k][7:0], p[k][15:8]});
            chk("R3", "irq_mask_o", irq_mask_o, {p[k][7:0], p[k][15:8]});
            rd(6'h00, p[k], "R3");
            rd(6'h02, p[k] ^ 16'h1, "R3");
            rd(6'h0A, ~p[k], "R3");
            rd(6'h0C, p[k] + 16'h3, "R3");
            rd(6'h0E, {p[k][7:0], p[k][15:8]}, "R3");
        end
    endtask

    task automatic t_status();
        in_level_i = 16'h1234; single_hit_i = 16'h8421; multi_hit_i = 16'h0C30;
        rd(6'h04, 16'h1234, "R4");
        chk("R4", "no clr on level read", {14'b0, s_sclr, s_mclr}, 0);
        rd(6'h06, 16'h8421, "R4");
        chk("R4", "no clr on single read", {14'b0, s_sclr, s_mclr}, 0);
        rd(6'h08, 16'h0C30, "R4");
        chk("R4", "no clr on multi read", {14'b0, s_sclr, s_mclr}, 0);
    endtask

    task automatic t_rtc();
        single_hit_i = 16'h00F1; multi_hit_i = 16'h7000;
        rd(6'h16, 16'h00F1, "R5");
        chk("R5", "single clr in ack cycle", {15'b0, s_sclr}, 1);
        chk("R5", "multi clr stays low", {15'b0, s_mclr}, 0);
        @(negedge clk);
        chk("R5", "single clr one cycle", {15'b0, single_clr_o}, 0);
        rd(6'h18, 16'h7000, "R5");
        chk("R5", "multi clr in ack cycle", {15'b0, s_mclr}, 1);
        chk("R5", "single clr stays low", {15'b0, s_sclr}, 0);
        @(negedge clk);
        chk("R5", "multi clr one cycle", {15'b0, multi_clr_o}, 0);
    endtask

    task automatic t_clear();
        bus(1'b1, 6'h00, 16'hFFFF);
        bus(1'b1, 6'h10, 16'h0000);
        chk("R6", "clear strobe", {15'b0, s_call}, 1);
        chk("R6", "in_set zeroed", in_set_o, 0);
        @(negedge clk);
        chk("R6", "clear one cycle", {15'b0, clear_all_o}, 0);
        rd(6'h10, 16'h0000, "R6");
    endtask

    task automatic t_test();
        test_button_i = 1'b1;
        bus(1'b1, 6'h1A, 16'h0007);
        chk("R7", "test masks", {13'b0, test_irq_mask_o, test_or_mask_o, test_out_mask_o}, 16'h7);
        chk("R7", "no test clr", {15'b0, s_tclr}, 0);
        rd(6'h1A, 16'h0017, "R7");
        test_button_i = 1'b0;
        bus(1'b1, 6'h1A, 16'hFFFA);
        chk("R7", "test clr pulse", {15'b0, s_tclr}, 1);
        chk("R7", "masks from write", {13'b0, test_irq_mask_o, test_or_mask_o, test_out_mask_o}, 16'h2);
        rd(6'h1A, 16'h0002, "R7");
    endtask

    task automatic t_irq();
        bus(1'b1, 6'h20, 16'hFFFD);
        chk("R8", "level out", {13'b0, irq_level_o}, 16'h5);
        rd(6'h20, 16'h0005, "R8");
        bus(1'b1, 6'h22, 16'hABCD);
        chk("R8", "vector out", {8'b0, irq_vector_o}, 16'hCD);
        rd(6'h22, 16'h00CD, "R8");
    endtask

    task automatic t_ro();
        in_level_i = 16'h0F0F;
        bus(1'b1, 6'h24, 16'hFFFF);
        bus(1'b1, 6'h26, 16'hFFFF);
        bus(1'b1, 6'h04, 16'hFFFF);
        rd(6'h24, SER, "R9");
        rd(6'h26, FW, "R9");
        rd(6'h04, 16'h0F0F, "R9");
    endtask

    task automatic t_ctrl();
        bus(1'b1, 6'h28, 16'hFFFD);
        chk("R10", "ctrl bits", {13'b0, or_mask_o, gate_mask_o, mode_o}, 16'h5);
        rd(6'h28, 16'h0005, "R10");
    endtask

    task automatic t_scratch();
        bus(1'b1, 6'h2A, 16'hA5C3);
        rd(6'h2A, 16'hA5C3, "R11");
        bus(1'b1, 6'h2A, 16'h5A3C);
        rd(6'h2A, 16'h5A3C, "R11");
    endtask

    task automatic t_reserved();
        logic [15:0] snap_mask;
        bus(1'b1, 6'h02, 16'h3C3C);
        snap_mask = in_mask_o;
        foreach (p_res[k]) begin
            bus(1'b1, p_res[k], 16'hFFFF);
            rd(p_res[k], 16'h0000, "R13");
        end
        bus(1'b1, 6'h03, 16'hFFFF);   // odd byte offset next to input mask
        rd(6'h03, 16'h0000, "R13");
        chk("R13", "in_mask unchanged", in_mask_o, snap_mask);
        chk("R13", "ctrl unchanged", {13'b0, or_mask_o, gate_mask_o, mode_o}, 16'h5);
        rd(6'h2A, 16'h5A3C, "R13");
        rd(6'h20, 16'h0005, "R13");
    endtask

    logic [5:0] p_res [7] = '{6'h12, 6'h14, 6'h1C, 6'h1E, 6'h2C, 6'h30, 6'h3E};

    task automatic t_swrst();
        bus(1'b1, 6'h0A, 16'h1111);
        bus(1'b1, 6'h2E, 16'h0000);
        chk("R12", "out_set default", out_set_o, 0);
        chk("R12", "in_mask default", in_mask_o, 0);
        chk("R12", "irq_mask default", irq_mask_o, 0);
        chk("R12", "level default", {13'b0, irq_level_o}, 0);
        chk("R12", "vector default", {8'b0, irq_vector_o}, 16'hDD);
        chk("R12", "ctrl default", {13'b0, or_mask_o, gate_mask_o, mode_o}, 16'h2);
        chk("R12", "test default", {13'b0, test_irq_mask_o, test_or_mask_o, test_out_mask_o}, 0);
        rd(6'h2A, 16'h5555, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_status();
        t_rtc();
        t_clear();
        t_test();
        t_irq();
        t_ro();
        t_ctrl();
        t_scratch();
        t_reserved();
        t_swrst();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule